// File: doc/BRIEF.md
# In-Order Completion Retry Buffer

This block keeps one record per fragment that is waiting for its filtered texture result. A record is written when the fragment enters the texture path. The record holds the screen coordinate (x, y) and an opaque request word that carries the filtering information and the texture address. The slot index used for the record is returned at once, and it serves as the tag for that request. Filtered results can come back in any order. Each result names its tag and writes its texel data into that slot, which then becomes ready.

Records leave toward the shading side strictly in the order they were allocated. Retirement uses a valid/ready handshake. The oldest record is offered only once its result is present. A younger record that is already complete waits behind an older one that is not. The buffer is a circular structure of `DEPTH` slots, 32 by default. Each slot has an occupied flag and a ready flag.

Back-pressure rules: allocation takes place on a cycle where `alloc_valid` and `alloc_ready` are both high, and `alloc_ready` is low whenever every slot is occupied. Retirement takes place on a cycle where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the offered record does not change. Allocation and retirement may fire in the same cycle.

Top module: `frag_retire_buf`

## Requirements
- R1: After reset, `out_valid` is 0, `alloc_ready` is 1, `alloc_tag` is 0 and `upd_err` is 0.
- R2: `alloc_tag` gives the slot that the next allocation uses. Slots are handed out as 0, 1, 2 … `DEPTH-1`, and after `DEPTH-1` the next slot is 0 again.
- R3: Once `DEPTH` records are occupied, `alloc_ready` is 0. An `alloc_valid` asserted while the buffer is full stores nothing.
- R4: `out_valid` is 1 only when the oldest occupied record has its result. Completed younger records do not make `out_valid` 1.
- R5: Records retire in allocation order. Each retired record shows its own `out_x`, `out_y` and `out_info`, and the `out_data` written for its tag, whatever order the results arrived in.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_x`, `out_y`, `out_info` and `out_data` stay unchanged.
- R7: An update to an unoccupied slot changes nothing. `upd_err` is then 1 for exactly the one cycle after the update; otherwise `upd_err` is 0.
- R8: An update to a slot whose result is already present is ignored, so the first data is kept, and it raises `upd_err` in the same way as R7.
- R9: When an allocation and a retirement happen in the same cycle, the occupancy is unchanged. From 31 occupied slots, one such cycle followed by one more allocation makes `alloc_ready` 0.
- R10: Retirement frees the slot. A later update to that tag, made before the slot is allocated again, raises `upd_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | A new record is offered |
| alloc_ready | output | 1 | A free slot exists |
| alloc_x | input | XW | Screen x of the new record |
| alloc_y | input | YW | Screen y of the new record |
| alloc_info | input | IW | Request word (filtering info and texture address) |
| alloc_tag | output | $clog2(DEPTH) | Slot taken by the next allocation |
| upd_valid | input | 1 | A filtered result is delivered |
| upd_tag | input | $clog2(DEPTH) | Slot the result belongs to |
| upd_data | input | DW | Filtered texel data |
| upd_err | output | 1 | One-cycle pulse after a rejected update |
| out_valid | output | 1 | Oldest record is complete |
| out_ready | input | 1 | Consumer accepts the offered record |
| out_x | output | XW | Screen x of the offered record |
| out_y | output | YW | Screen y of the offered record |
| out_info | output | IW | Request word of the offered record |
| out_data | output | DW | Filtered data of the offered record |

## Verification
Results are returned in several orders. In the reverse order, the oldest record completes last. In a scattered order, a gap sits in the middle of the queue. Running both shows that the output waits for the oldest slot rather than for any ready slot. A complete fill to capacity followed by a wrap-around separates correct modulo pointer behaviour from off-by-one full detection. Stalling the consumer shows that the offered record is held steady. Updates to empty, already-complete and just-retired slots show the difference between the occupied check and the ready check. A cycle that allocates and retires at once, made at 31 occupied slots, shows whether the occupancy count handles both events together.

// File: rtl/frb_pkg.sv
package frb_pkg;
  typedef enum logic [1:0] {
    UPD_NONE = 2'd0,
    UPD_OK   = 2'd1,
    UPD_BAD  = 2'd2
  } upd_verdict_e;
endpackage

// File: rtl/frb_ptr.sv
module frb_ptr #(
  parameter int DEPTH = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] tail,
  output logic [CW-1:0]    count,
  output logic             full
);
  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (push) tail <= step(tail);
      if (pop)  head <= step(head);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign full = (count == CW'(DEPTH));
endmodule

// File: rtl/frb_store.sv
module frb_store
  import frb_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int XW = 12,
  parameter int YW = 12,
  parameter int IW = 24,
  parameter int DW = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [XW-1:0]    wr_x,
  input  logic [YW-1:0]    wr_y,
  input  logic [IW-1:0]    wr_info,
  input  logic             upd_valid,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic [DW-1:0]    upd_data,
  output upd_verdict_e     verdict,
  input  logic             free_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_occ,
  output logic             rd_done,
  output logic [XW-1:0]    rd_x,
  output logic [YW-1:0]    rd_y,
  output logic [IW-1:0]    rd_info,
  output logic [DW-1:0]    rd_data
);
  logic            occ_w  [DEPTH];
  logic            done_w [DEPTH];
  logic [XW-1:0]   x_w    [DEPTH];
  logic [YW-1:0]   y_w    [DEPTH];
  logic [IW-1:0]   info_w [DEPTH];
  logic [DW-1:0]   data_w [DEPTH];
  logic            upd_ok;

  always_comb begin
    verdict = UPD_NONE;
    if (upd_valid) begin
      if (32'(upd_idx) < DEPTH && occ_w[upd_idx] && !done_w[upd_idx])
        verdict = UPD_OK;
      else
        verdict = UPD_BAD;
    end
  end

  assign upd_ok = (verdict == UPD_OK);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic          occ_q, done_q;
    logic [XW-1:0] x_q;
    logic [YW-1:0] y_q;
    logic [IW-1:0] info_q;
    logic [DW-1:0] data_q;
    logic          hit_wr, hit_free, hit_upd;

    assign hit_wr   = wr_en && (wr_idx == IDX_W'(g));
    assign hit_free = free_en && (rd_idx == IDX_W'(g));
    assign hit_upd  = upd_ok && (upd_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        occ_q  <= 1'b0;
        done_q <= 1'b0;
      end else if (hit_wr) begin
        occ_q  <= 1'b1;
        done_q <= 1'b0;
      end else if (hit_free) begin
        occ_q  <= 1'b0;
        done_q <= 1'b0;
      end else if (hit_upd) begin
        done_q <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (hit_wr) begin
        x_q    <= wr_x;
        y_q    <= wr_y;
        info_q <= wr_info;
      end
      if (hit_upd) data_q <= upd_data;
    end

    assign occ_w[g]  = occ_q;
    assign done_w[g] = done_q;
    assign x_w[g]    = x_q;
    assign y_w[g]    = y_q;
    assign info_w[g] = info_q;
    assign data_w[g] = data_q;
  end

  assign rd_occ  = occ_w[rd_idx];
  assign rd_done = done_w[rd_idx];
  assign rd_x    = x_w[rd_idx];
  assign rd_y    = y_w[rd_idx];
  assign rd_info = info_w[rd_idx];
  assign rd_data = data_w[rd_idx];
endmodule

// File: rtl/frag_retire_buf.sv
module frag_retire_buf
  import frb_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int XW = 12,
  parameter int YW = 12,
  parameter int IW = 24,
  parameter int DW = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_valid,
  output logic             alloc_ready,
  input  logic [XW-1:0]    alloc_x,
  input  logic [YW-1:0]    alloc_y,
  input  logic [IW-1:0]    alloc_info,
  output logic [IDX_W-1:0] alloc_tag,
  input  logic             upd_valid,
  input  logic [IDX_W-1:0] upd_tag,
  input  logic [DW-1:0]    upd_data,
  output logic             upd_err,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [XW-1:0]    out_x,
  output logic [YW-1:0]    out_y,
  output logic [IW-1:0]    out_info,
  output logic [DW-1:0]    out_data
);
  logic [IDX_W-1:0] head_idx, tail_idx;
  logic [CW-1:0]    occ_cnt;
  logic             is_full, take, retire, head_occ, head_done;
  upd_verdict_e     verdict;

  assign alloc_ready = !is_full;
  assign take        = alloc_valid && alloc_ready;
  assign out_valid   = head_occ && head_done;
  assign retire      = out_valid && out_ready;
  assign alloc_tag   = tail_idx;

  frb_ptr #(.DEPTH(DEPTH)) i_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (take),
    .pop   (retire),
    .head  (head_idx),
    .tail  (tail_idx),
    .count (occ_cnt),
    .full  (is_full)
  );

  frb_store #(.DEPTH(DEPTH), .XW(XW), .YW(YW), .IW(IW), .DW(DW)) i_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (take),
    .wr_idx    (tail_idx),
    .wr_x      (alloc_x),
    .wr_y      (alloc_y),
    .wr_info   (alloc_info),
    .upd_valid (upd_valid),
    .upd_idx   (upd_tag),
    .upd_data  (upd_data),
    .verdict   (verdict),
    .free_en   (retire),
    .rd_idx    (head_idx),
    .rd_occ    (head_occ),
    .rd_done   (head_done),
    .rd_x      (out_x),
    .rd_y      (out_y),
    .rd_info   (out_info),
    .rd_data   (out_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) upd_err <= 1'b0;
    else        upd_err <= (verdict == UPD_BAD);
  end
endmodule

// File: rtl/frb_check.sv
module frb_check #(
  parameter int DEPTH = 32,
  parameter int XW = 12,
  parameter int YW = 12,
  parameter int IW = 24,
  parameter int DW = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_valid,
  input logic             alloc_ready,
  input logic [IDX_W-1:0] alloc_tag,
  input logic             upd_valid,
  input logic             upd_err,
  input logic             out_valid,
  input logic             out_ready,
  input logic [XW-1:0]    out_x,
  input logic [YW-1:0]    out_y,
  input logic [IW-1:0]    out_info,
  input logic [DW-1:0]    out_data,
  input logic [CW-1:0]    occ_cnt
);
  logic [CW-1:0]    occ_m;
  logic [IDX_W-1:0] tag_nxt;
  logic             fire_in, fire_out;

  assign fire_in  = alloc_valid && alloc_ready;
  assign fire_out = out_valid && out_ready;
  assign tag_nxt  = (alloc_tag == IDX_W'(DEPTH - 1)) ? '0 : alloc_tag + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) occ_m <= '0;
    else        occ_m <= occ_m + CW'(fire_in) - CW'(fire_out);
  end

  a_r3_no_alloc_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_m == CW'(DEPTH)) |-> !alloc_ready);

  a_r9_occ_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    occ_m == occ_cnt);

  a_r2_tag_step: assert property (@(posedge clk) disable iff (!rst_n)
    fire_in |=> (alloc_tag == $past(tag_nxt)));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_x) && $stable(out_y)
                                   && $stable(out_info) && $stable(out_data)));

  a_r7_err_after_upd: assert property (@(posedge clk) disable iff (!rst_n)
    upd_err |-> $past(upd_valid));

  a_r4_valid_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (occ_m != '0));
endmodule

bind frag_retire_buf frb_check #(
  .DEPTH(DEPTH), .XW(XW), .YW(YW), .IW(IW), .DW(DW)
) i_frb_check (
  .clk         (clk),
  .rst_n       (rst_n),
  .alloc_valid (alloc_valid),
  .alloc_ready (alloc_ready),
  .alloc_tag   (alloc_tag),
  .upd_valid   (upd_valid),
  .upd_err     (upd_err),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_x       (out_x),
  .out_y       (out_y),
  .out_info    (out_info),
  .out_data    (out_data),
  .occ_cnt     (occ_cnt)
);

// File: tb/test_frag_retire_buf.sv
`timescale 1ns/1ps
module test_frag_retire_buf;
  localparam int DEPTH = 32;
  localparam int XW = 12, YW = 12, IW = 24, DW = 32;
  localparam int IDX_W = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_valid = 1'b0, upd_valid = 1'b0, out_ready = 1'b0;
  logic [XW-1:0] alloc_x = '0;
  logic [YW-1:0] alloc_y = '0;
  logic [IW-1:0] alloc_info = '0;
  logic [IDX_W-1:0] upd_tag = '0;
  logic [DW-1:0] upd_data = '0;
  logic alloc_ready, upd_err, out_valid;
  logic [IDX_W-1:0] alloc_tag;
  logic [XW-1:0] out_x;
  logic [YW-1:0] out_y;
  logic [IW-1:0] out_info;
  logic [DW-1:0] out_data;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  frag_retire_buf #(.DEPTH(DEPTH), .XW(XW), .YW(YW), .IW(IW), .DW(DW)) i_frag_retire_buf (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_x(alloc_x),
    .alloc_y(alloc_y), .alloc_info(alloc_info), .alloc_tag(alloc_tag),
    .upd_valid(upd_valid), .upd_tag(upd_tag), .upd_data(upd_data), .upd_err(upd_err),
    .out_valid(out_valid), .out_ready(out_ready), .out_x(out_x), .out_y(out_y),
    .out_info(out_info), .out_data(out_data)
  );

  function automatic logic [XW-1:0] fx(int s); return XW'(s); endfunction
  function automatic logic [YW-1:0] fy(int s); return YW'(s + 100); endfunction
  function automatic logic [IW-1:0] fi(int s); return IW'(s * 7 + 3); endfunction
  function automatic logic [DW-1:0] fd(int s); return DW'(s * 13 + 1); endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; alloc_valid = 1'b0; upd_valid = 1'b0; out_ready = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_alloc(int s, output int tag, output bit rdy);
    alloc_valid = 1'b1; alloc_x = fx(s); alloc_y = fy(s); alloc_info = fi(s);
    tag = int'(alloc_tag); rdy = alloc_ready;
    @(negedge clk);
    alloc_valid = 1'b0;
  endtask

  task automatic do_upd(int tag, logic [DW-1:0] d, output bit err);
    upd_valid = 1'b1; upd_tag = IDX_W'(tag); upd_data = d;
    @(negedge clk);
    upd_valid = 1'b0;
    err = upd_err;
  endtask

  task automatic pop_chk(int s, string req);
    for (int w = 0; w < 20 && !out_valid; w++) @(negedge clk);
    chk(req, "out_valid", out_valid, 1);
    chk(req, "out_x", out_x, fx(s));
    chk(req, "out_y", out_y, fy(s));
    chk(req, "out_info", out_info, fi(s));
    chk(req, "out_data", out_data, fd(s));
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "out_valid", out_valid, 0);
    chk("R1", "alloc_ready", alloc_ready, 1);
    chk("R1", "alloc_tag", alloc_tag, 0);
    chk("R1", "upd_err", upd_err, 0);
  endtask

  task automatic t_fill_wrap();
    int tag; bit rdy, err;
    do_reset();
    for (int i = 0; i < DEPTH; i++) begin
      do_alloc(i, tag, rdy);
      chk("R2", "tag order", tag, i);
      chk("R3", "ready before full", rdy, 1);
    end
    chk("R3", "alloc_ready when full", alloc_ready, 0);
    do_alloc(999, tag, rdy);
    chk("R3", "ready during refused alloc", rdy, 0);
    for (int i = DEPTH - 1; i >= 1; i--) do_upd(i, fd(i), err);
    chk("R4", "head pending, younger done", out_valid, 0);
    do_upd(0, fd(0), err);
    chk("R7", "good update no error", err, 0);
    for (int i = 0; i < DEPTH; i++) pop_chk(i, "R5");
    chk("R3", "no extra record after drain", out_valid, 0);
    chk("R3", "alloc_ready after drain", alloc_ready, 1);
    do_alloc(200, tag, rdy);
    chk("R2", "wrap to slot 0", tag, 0);
    do_upd(0, fd(200), err);
    pop_chk(200, "R2");
  endtask

  task automatic t_out_of_order();
    int tag; bit rdy, err;
    do_reset();
    for (int s = 1; s <= 4; s++) do_alloc(s, tag, rdy);
    do_upd(3, fd(4), err);
    do_upd(1, fd(2), err);
    chk("R4", "oldest not done", out_valid, 0);
    do_upd(0, fd(1), err);
    pop_chk(1, "R5");
    pop_chk(2, "R5");
    chk("R4", "gap at slot 2", out_valid, 0);
    do_upd(2, fd(3), err);
    pop_chk(3, "R5");
    pop_chk(4, "R5");
  endtask

  task automatic t_backpressure();
    int tag; bit rdy, err;
    do_reset();
    do_alloc(10, tag, rdy);
    do_upd(0, fd(10), err);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk("R6", "valid held", out_valid, 1);
      chk("R6", "data held", out_data, fd(10));
      chk("R6", "x held", out_x, fx(10));
    end
    do_upd(0, fd(55), err);
    chk("R8", "duplicate update error", err, 1);
    chk("R8", "first data kept", out_data, fd(10));
    pop_chk(10, "R6");
  endtask

  task automatic t_errors();
    int tag; bit rdy, err;
    do_reset();
    do_upd(5, fd(77), err);
    chk("R7", "error on empty slot", err, 1);
    @(negedge clk);
    chk("R7", "error is one pulse", upd_err, 0);
    chk("R7", "no record appeared", out_valid, 0);
    chk("R7", "tag unchanged", alloc_tag, 0);
    do_alloc(20, tag, rdy);
    do_upd(0, fd(20), err);
    chk("R7", "no error on occupied slot", err, 0);
    pop_chk(20, "R10");
    do_upd(0, fd(21), err);
    chk("R10", "error after retire", err, 1);
    chk("R10", "retired slot not offered", out_valid, 0);
  endtask

  task automatic t_simultaneous();
    int tag; bit rdy, err;
    do_reset();
    for (int s = 0; s < DEPTH - 1; s++) do_alloc(s, tag, rdy);
    do_upd(0, fd(0), err);
    chk("R9", "head ready", out_valid, 1);
    chk("R9", "room before joint cycle", alloc_ready, 1);
    chk("R9", "tag before joint cycle", alloc_tag, DEPTH - 1);
    alloc_valid = 1'b1; alloc_x = fx(31); alloc_y = fy(31); alloc_info = fi(31);
    out_ready = 1'b1;
    @(negedge clk);
    alloc_valid = 1'b0; out_ready = 1'b0;
    chk("R9", "still room after joint cycle", alloc_ready, 1);
    do_alloc(32, tag, rdy);
    chk("R9", "tag after joint cycle", tag, 0);
    chk("R9", "full after one more", alloc_ready, 0);
    for (int t = 1; t < DEPTH; t++) do_upd(t, fd(t), err);
    do_upd(0, fd(32), err);
    for (int s = 1; s <= 32; s++) pop_chk(s, "R9");
    chk("R9", "empty after drain", out_valid, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_fill_wrap();
    t_out_of_order();
    t_backpressure();
    t_errors();
    t_simultaneous();
    finish_run();
  end
endmodule